// File: doc/BRIEF.md
# Synchronous Serial Transmit Shifter

This block is the transmit half of an SPI-style link. Software or a neighbouring engine loads a data word with a one-cycle strobe. The block then shifts that word out, one bit for each rising edge of a serial clock that some other logic generates. The serial clock is sampled in the system clock domain. The block picks one of several clock inputs, can invert the chosen input, and detects rising edges by comparing two successive samples.

The first bit of a word appears on the data output as soon as the word is loaded, so it is already valid when the first serial clock edge arrives. Bits leave least significant first. A caller that needs MSB-first order reverses the word before loading it. A configuration word sets the word length and the load behaviour. In start/stop behaviour every load restarts the transfer. In streaming behaviour a load made during a transfer waits until the current word ends, and the next word then follows without a gap.

Top module: `sync_tx_shifter`

## Requirements
- R1: While reset is asserted and afterwards until the first load, `sdo` is 0 and `done` is 0.
- R2: On the system clock after a load, `sdo` equals bit 0 of the loaded word and `done` is 0, with no serial clock edge needed.
- R3: Each rising edge of the effective serial clock shifts the word right by one, so bit k of the word is on `sdo` after k edges. The change shows on the second system clock edge after the serial clock input rises: one edge samples the input and the next edge acts on it.
- R4: `cfg[4:0]` holds the word length minus one (7 means 8 bits). `done` rises together with the shift slot of edge number `cfg[4:0]+1` and not earlier. This includes the 3-bit and 32-bit lengths.
- R5: After the last bit, `sdo` keeps that bit and `done` stays 1 through any further serial clock edges until the next load.
- R6: Falling edges of the effective serial clock change nothing.
- R7: With `sclk_inv` = 1, the selected input is inverted before edge detection, so falling edges on the pin shift and rising edges on the pin do not.
- R8: `sclk_sel` picks which bit of `sclk_in` is the serial clock. Edges on the other input have no effect.
- R9: With `cfg[5]` = 1 (start/stop), a load during a transfer drops the current word. The new word's bit 0 appears on the next cycle and a full new count of edges follows.
- R10: With `cfg[5]` = 0 (streaming), a load during a transfer is queued and `sdo` is not disturbed. At the final edge of the current word, bit 0 of the queued word replaces the last bit without `done` pulsing. The queued word then runs its own full count.
- R11: With `cfg[5]` = 0 and no transfer running, a load starts at once, as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sclk_in | input | NCLK (2) | Candidate serial clock inputs |
| sclk_sel | input | SELW (1) | Index of the serial clock input used |
| sclk_inv | input | 1 | Invert the selected serial clock before edge detection |
| cfg | input | CW+1 (6) | [4:0] word length minus one, [5] start/stop when 1, streaming when 0 |
| load | input | 1 | One-cycle strobe that loads `load_data` |
| load_data | input | DW (32) | Word to transmit, LSB first |
| sdo | output | 1 | Serial data out |
| done | output | 1 | High once the configured bit count has been shifted, cleared by a load |

## Verification
The bench samples `sdo` exactly two system clocks after each serial clock change. A design that acted on the same cycle it sampled, or one cycle late, would show the wrong bit there. It probes done one edge before and exactly at the configured count for 3, 8 and 32 bits, which catches off-by-one counters that end one bit early or late. Streaming is checked across the word boundary. A design that restarted instead of queueing, or that pulsed done between words, would miscompare at the handover. Inversion and input selection are each driven with edges that must be ignored, which exposes a swapped polarity or a wrong input mux.

// File: rtl/sync_tx_shifter.sv
module sync_tx_shifter #(
  parameter int DW   = 32,
  parameter int CW   = 5,
  parameter int NCLK = 2,
  localparam int SELW = (NCLK > 1) ? $clog2(NCLK) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCLK-1:0] sclk_in,
  input  logic [SELW-1:0] sclk_sel,
  input  logic            sclk_inv,
  input  logic [CW:0]     cfg,
  input  logic            load,
  input  logic [DW-1:0]   load_data,
  output logic            sdo,
  output logic            done
);

  logic          s_now, s_prev;
  logic [DW-1:0] shreg, hold;
  logic [CW-1:0] cnt;
  logic          busy, hold_v;

  wire pick       = sclk_in[sclk_sel] ^ sclk_inv;
  wire rise       = s_now & ~s_prev;
  wire start_stop = cfg[CW];
  wire last       = (cnt == cfg[CW-1:0]);
  wire take_new   = load & (start_stop | ~busy);
  wire finish     = busy & rise & last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_now  <= 1'b0;
      s_prev <= 1'b0;
    end else begin
      s_now  <= pick;
      s_prev <= s_now;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg  <= '0;
      hold   <= '0;
      cnt    <= '0;
      busy   <= 1'b0;
      hold_v <= 1'b0;
      done   <= 1'b0;
    end else if (take_new) begin
      shreg  <= load_data;
      cnt    <= '0;
      busy   <= 1'b1;
      hold_v <= 1'b0;
      done   <= 1'b0;
    end else if (finish) begin
      if (hold_v) begin
        shreg  <= hold;
        cnt    <= '0;
        hold_v <= load;
        if (load) hold <= load_data;
      end else if (load) begin
        shreg <= load_data;
        cnt   <= '0;
      end else begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end else begin
      if (busy && rise) begin
        shreg <= shreg >> 1;
        cnt   <= cnt + 1'b1;
      end
      if (load) begin
        hold   <= load_data;
        hold_v <= 1'b1;
      end
    end
  end

  assign sdo = shreg[0];

endmodule

// File: rtl/sync_tx_shifter_chk.sv
module sync_tx_shifter_chk #(
  parameter int DW = 32,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW:0]   cfg,
  input logic          load,
  input logic [DW-1:0] load_data,
  input logic          sdo,
  input logic          done,
  input logic          rise,
  input logic          busy
);

  assert_load_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && cfg[CW]) |=> (sdo == $past(load_data[0])) && !done);

  assert_quiet_no_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise && !load) |=> $stable(sdo));

  assert_done_not_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> done);

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !load) |=> $stable(sdo));

  assert_restart_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (load && cfg[CW]) |=> !done && busy);

endmodule

bind sync_tx_shifter sync_tx_shifter_chk #(.DW(DW), .CW(CW)) chk (
  .clk(clk), .rst_n(rst_n), .cfg(cfg), .load(load), .load_data(load_data),
  .sdo(sdo), .done(done), .rise(rise), .busy(busy)
);

// File: tb/sync_tx_shifter_test.sv
module sync_tx_shifter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  sclk_in = 2'b00;
  logic [0:0]  sclk_sel = 1'b0;
  logic        sclk_inv = 1'b0;
  logic [5:0]  cfg = 6'h27;
  logic        load = 1'b0;
  logic [31:0] load_data = '0;
  logic        sdo, done;
  int          n_checks = 0;
  int          n_fails = 0;

  always #2 clk = ~clk;

  sync_tx_shifter uut (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .sclk_sel(sclk_sel),
    .sclk_inv(sclk_inv), .cfg(cfg), .load(load), .load_data(load_data),
    .sdo(sdo), .done(done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic line(input int idx, input logic v);
    @(negedge clk) sclk_in[idx] = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(input int idx);
    line(idx, 1'b1);
    line(idx, 1'b0);
  endtask

  task automatic do_load(input logic [31:0] w);
    @(negedge clk) begin load = 1'b1; load_data = w; end
    @(negedge clk) load = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 sdo in reset", sdo, 0);
    check("R1 done in reset", done, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 sdo after reset", sdo, 0);
    check("R1 done after reset", done, 0);
  endtask

  task automatic t_basic;
    logic [31:0] w = 32'h0000_004D;
    cfg = 6'h27;
    do_load(w);
    check("R2 first bit", sdo, w[0]);
    check("R2 done low", done, 0);
    for (int k = 1; k <= 7; k++) begin
      line(0, 1'b1);
      check("R3 bit after rise", sdo, w[k]);
      line(0, 1'b0);
      check("R6 falling edge ignored", sdo, w[k]);
      check("R4 done not early", done, 0);
    end
    pulse(0);
    check("R4 done at count", done, 1);
    check("R5 last bit held", sdo, w[7]);
    pulse(0);
    pulse(0);
    check("R5 extra edges ignored sdo", sdo, w[7]);
    check("R5 extra edges done", done, 1);
  endtask

  task automatic t_width(input int nbits, input logic [31:0] w);
    cfg = {1'b1, 5'(nbits - 1)};
    do_load(w);
    check("R2 first bit width", sdo, w[0]);
    for (int k = 1; k < nbits; k++) pulse(0);
    check("R4 bit before last", sdo, w[nbits-1]);
    check("R4 no done one edge early", done, 0);
    pulse(0);
    check("R4 done at configured length", done, 1);
    check("R5 hold last", sdo, w[nbits-1]);
  endtask

  task automatic t_invert;
    logic [31:0] w = 32'h0000_0005;
    cfg = 6'h22;
    @(negedge clk) sclk_inv = 1'b1;
    repeat (3) @(negedge clk);
    line(0, 1'b1);
    do_load(w);
    check("R7 first bit", sdo, w[0]);
    line(0, 1'b0);
    check("R7 pin fall shifts", sdo, w[1]);
    line(0, 1'b1);
    check("R7 pin rise ignored", sdo, w[1]);
    line(0, 1'b0);
    check("R7 second shift", sdo, w[2]);
    line(0, 1'b1);
    line(0, 1'b0);
    check("R7 done", done, 1);
    @(negedge clk) sclk_inv = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_select;
    logic [31:0] w = 32'h0000_0002;
    cfg = 6'h21;
    @(negedge clk) sclk_sel = 1'b1;
    repeat (3) @(negedge clk);
    do_load(w);
    pulse(0);
    check("R8 other input ignored", sdo, w[0]);
    pulse(1);
    check("R8 selected input shifts", sdo, w[1]);
    pulse(1);
    check("R8 done", done, 1);
    @(negedge clk) sclk_sel = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_restart;
    logic [31:0] a = 32'h0000_00F0;
    logic [31:0] b = 32'h0000_000B;
    cfg = 6'h23;
    do_load(a);
    pulse(0);
    pulse(0);
    check("R9 mid word", sdo, a[2]);
    do_load(b);
    check("R9 restart first bit", sdo, b[0]);
    check("R9 done low", done, 0);
    for (int k = 1; k < 4; k++) begin
      pulse(0);
      check("R9 new word bits", sdo, b[k]);
    end
    check("R9 not done before count", done, 0);
    pulse(0);
    check("R9 done after full count", done, 1);
  endtask

  task automatic t_stream;
    logic [31:0] a = 32'h0000_0006;
    logic [31:0] b = 32'h0000_0009;
    cfg = 6'h03;
    do_load(a);
    check("R11 idle load starts", sdo, a[0]);
    check("R11 done cleared", done, 0);
    pulse(0);
    pulse(0);
    do_load(b);
    check("R10 queued load keeps sdo", sdo, a[2]);
    pulse(0);
    check("R10 current word continues", sdo, a[3]);
    pulse(0);
    check("R10 handover to queued word", sdo, b[0]);
    check("R10 no done between words", done, 0);
    for (int k = 1; k < 4; k++) begin
      pulse(0);
      check("R10 queued word bits", sdo, b[k]);
    end
    check("R10 done not early", done, 0);
    pulse(0);
    check("R10 done after queued word", done, 1);
    check("R10 hold last", sdo, b[3]);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_width(3, 32'h0000_0005);
    t_width(32, 32'hA5C3_0F96);
    t_invert();
    t_select();
    t_restart();
    t_stream();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    #400000;
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule